// File: doc/BRIEF.md
# Processor Register File with Constant Entries

This block is the architectural register storage of a small multi-cycle processor. It holds sixteen 16-bit entries. Two combinational read ports serve the operand fetch, and one synchronous write port takes results back. Each port is addressed by a 4-bit index.

Two entries are fixed constants, so the instruction encoding can name zero or all-ones without loading them first. One entry is the stack pointer. Another is the instruction pointer, which the control unit advances through a dedicated increment strobe. Jumps and returns overwrite the instruction pointer through the ordinary write port. Both pointers are also brought out as separate outputs for the fetch and stack logic.

Top module: `cpu_regfile`

## Requirements
- R1: The file has 16 entries of 16 bits. The index map is: 0 assembler temporary, 1 zero constant, 2 ones constant, 3 to 9 preserved general registers, 10 to 13 scratch registers, 14 stack pointer, 15 instruction pointer.
- R2: Index 1 always reads 0x0000 on both read ports. Writes to index 1 change nothing.
- R3: Index 2 always reads 0xFFFF on both read ports. Writes to index 2 change nothing.
- R4: When `wr_en` is high at a rising clock edge, `wr_data` is stored in the writable entry `wr_idx`. The new value is readable from the next cycle, and all other entries keep their values.
- R5: Reads are combinational. Reading an entry in the same cycle as a write to it returns the old value.
- R6: When `ip_inc` is high at a rising edge, entry 15 increases by 1, wrapping from 0xFFFF to 0x0000. With neither a write nor an increment, entry 15 holds its value.
- R7: If entry 15 is written while `ip_inc` is high in the same cycle, the written value is stored and the increment is dropped.
- R8: While `rst` is high at a rising edge, every writable entry is cleared to 0x0000. Reset takes priority over writes and increments.
- R9: `ip_out` always equals entry 15 and `sp_out` always equals entry 14.
- R10: The two read ports are independent and may address the same entry in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 16 | Write value |
| ip_inc | input | 1 | Instruction pointer increment strobe |
| rd_a_idx | input | 4 | Read port A index |
| rd_a_data | output | 16 | Read port A value |
| rd_b_idx | input | 4 | Read port B index |
| rd_b_data | output | 16 | Read port B value |
| ip_out | output | 16 | Current instruction pointer |
| sp_out | output | 16 | Current stack pointer |

## Verification
A wrongly stored value shows up on a read port in the first cycle that entry is addressed. A bad instruction pointer or stack pointer shows up one cycle after the faulty edge, because `ip_out` and `sp_out` are permanently visible. A constant that can be overwritten is caught on the cycle after the write, when the bench reads that index back. The bench compares all four outputs against a behavioural model twice per cycle: once before the edge, which checks that reads return old values, and once after it, which checks the update.

// File: rtl/cpu_rf_pkg.sv
package cpu_rf_pkg;

    localparam int RF_DATA_W  = 16;
    localparam int RF_ENTRIES = 16;
    localparam int RF_IDX_W   = $clog2(RF_ENTRIES);

    typedef logic [RF_DATA_W-1:0] rf_word_t;
    typedef logic [RF_IDX_W-1:0]  rf_idx_t;

    typedef enum logic [1:0] {
        SLOT_STORED = 2'd0,
        SLOT_ZERO   = 2'd1,
        SLOT_ONES   = 2'd2
    } slot_kind_e;

    localparam rf_idx_t IDX_AT      = 4'd0;
    localparam rf_idx_t IDX_ZERO    = 4'd1;
    localparam rf_idx_t IDX_ONES    = 4'd2;
    localparam rf_idx_t IDX_PRES_LO = 4'd3;
    localparam rf_idx_t IDX_PRES_HI = 4'd9;
    localparam rf_idx_t IDX_SCR_LO  = 4'd10;
    localparam rf_idx_t IDX_SCR_HI  = 4'd13;
    localparam rf_idx_t IDX_SP      = 4'd14;
    localparam rf_idx_t IDX_IP      = 4'd15;

    // Kind of storage behind each index
    function automatic slot_kind_e slot_kind(int unsigned i);
        if (i == int'(IDX_ZERO)) return SLOT_ZERO;
        if (i == int'(IDX_ONES)) return SLOT_ONES;
        if (i == int'(IDX_AT)) return SLOT_STORED;
        if (i >= int'(IDX_PRES_LO) && i <= int'(IDX_PRES_HI)) return SLOT_STORED;
        if (i >= int'(IDX_SCR_LO) && i <= int'(IDX_SCR_HI)) return SLOT_STORED;
        return SLOT_STORED; // stack and instruction pointers
    endfunction

    function automatic rf_word_t const_value(slot_kind_e k);
        return (k == SLOT_ONES) ? {RF_DATA_W{1'b1}} : {RF_DATA_W{1'b0}};
    endfunction

endpackage

// File: rtl/rf_wr_decode.sv
module rf_wr_decode
    import cpu_rf_pkg::*;
#(
    parameter int N  = RF_ENTRIES,
    parameter int IW = RF_IDX_W
) (
    input  logic          en,
    input  logic [IW-1:0] idx,
    output logic [N-1:0]  we_vec
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        if (slot_kind(i) == SLOT_STORED) begin : g_wr
            assign we_vec[i] = en && (idx == IW'(i));
        end else begin : g_ro
            assign we_vec[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rf_cell.sv
module rf_cell #(
    parameter int W = cpu_rf_pkg::RF_DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (we)  q <= d;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
    parameter int W  = cpu_rf_pkg::RF_DATA_W,
    parameter int N  = cpu_rf_pkg::RF_ENTRIES,
    parameter int IW = cpu_rf_pkg::RF_IDX_W
) (
    input  logic [N-1:0][W-1:0] words,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        data
);
    always_comb data = words[idx];
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
    import cpu_rf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [RF_IDX_W-1:0]  wr_idx,
    input  logic [RF_DATA_W-1:0] wr_data,
    input  logic                 ip_inc,
    input  logic [RF_IDX_W-1:0]  rd_a_idx,
    output logic [RF_DATA_W-1:0] rd_a_data,
    input  logic [RF_IDX_W-1:0]  rd_b_idx,
    output logic [RF_DATA_W-1:0] rd_b_data,
    output logic [RF_DATA_W-1:0] ip_out,
    output logic [RF_DATA_W-1:0] sp_out
);
    logic [RF_ENTRIES-1:0]                we_vec;
    logic [RF_ENTRIES-1:0][RF_DATA_W-1:0] words;

    rf_wr_decode #(.N(RF_ENTRIES), .IW(RF_IDX_W)) u_dec (
        .en(wr_en), .idx(wr_idx), .we_vec(we_vec)
    );

    for (genvar i = 0; i < RF_ENTRIES; i++) begin : g_slot
        localparam slot_kind_e KIND = slot_kind(i);
        if (KIND == SLOT_STORED) begin : g_store
            logic inc_i;
            if (i == int'(IDX_IP)) begin : g_ip
                assign inc_i = ip_inc;
            end else begin : g_plain
                assign inc_i = 1'b0;
            end
            rf_cell #(.W(RF_DATA_W)) u_cell (
                .clk(clk), .rst(rst), .we(we_vec[i]), .inc(inc_i),
                .d(wr_data), .q(words[i])
            );
        end else begin : g_const
            assign words[i] = const_value(KIND);
        end
    end

    rf_read_mux #(.W(RF_DATA_W), .N(RF_ENTRIES), .IW(RF_IDX_W)) u_rd_a (
        .words(words), .idx(rd_a_idx), .data(rd_a_data)
    );
    rf_read_mux #(.W(RF_DATA_W), .N(RF_ENTRIES), .IW(RF_IDX_W)) u_rd_b (
        .words(words), .idx(rd_b_idx), .data(rd_b_data)
    );

    assign ip_out = words[IDX_IP];
    assign sp_out = words[IDX_SP];
endmodule

// File: rtl/rf_checker.sv
module rf_checker
    import cpu_rf_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [RF_IDX_W-1:0]  wr_idx,
    input logic [RF_DATA_W-1:0] wr_data,
    input logic                 ip_inc,
    input logic [RF_IDX_W-1:0]  rd_a_idx,
    input logic [RF_DATA_W-1:0] rd_a_data,
    input logic [RF_IDX_W-1:0]  rd_b_idx,
    input logic [RF_DATA_W-1:0] rd_b_data,
    input logic [RF_DATA_W-1:0] ip_out,
    input logic [RF_DATA_W-1:0] sp_out
);
    AST_ZERO_A: assert property (@(posedge clk) disable iff (rst)
        rd_a_idx == IDX_ZERO |-> rd_a_data == '0); // R2
    AST_ONES_B: assert property (@(posedge clk) disable iff (rst)
        rd_b_idx == IDX_ONES |-> rd_b_data == '1); // R3
    AST_SP_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IDX_SP |=> sp_out == $past(wr_data)); // R4
    AST_IP_STEP: assert property (@(posedge clk) disable iff (rst)
        ip_inc && !(wr_en && wr_idx == IDX_IP) |=> ip_out == $past(ip_out) + 16'd1); // R6
    AST_IP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ip_inc && !(wr_en && wr_idx == IDX_IP) |=> $stable(ip_out)); // R6
    AST_IP_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_idx == IDX_IP |=> ip_out == $past(wr_data)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> ip_out == '0 && sp_out == '0); // R8
endmodule

bind cpu_regfile rf_checker u_rf_checker (.*);

// File: tb/tb_cpu_regfile.sv
`timescale 1ns/100ps
module tb_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic        ip_inc = 1'b0;
    logic [3:0]  rd_a_idx = '0;
    logic [3:0]  rd_b_idx = '0;
    logic [15:0] rd_a_data, rd_b_data, ip_out, sp_out;

    int tests = 0;
    int fails = 0;
    logic [15:0] model [16];

    always #2.5 clk = ~clk;

    cpu_regfile dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .ip_inc(ip_inc), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .ip_out(ip_out), .sp_out(sp_out)
    );

    function automatic logic [15:0] expect_rd(int i);
        if (i == 1) return 16'h0000;
        if (i == 2) return 16'hFFFF;
        return model[i];
    endfunction

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "port A", rd_a_data, expect_rd(int'(rd_a_idx)));
        check(req, "port B", rd_b_data, expect_rd(int'(rd_b_idx)));
        check("R9", "ip_out", ip_out, model[15]);
        check("R9", "sp_out", sp_out, model[14]);
    endtask

    // Called at a falling edge: drive, check old values, clock, update model, check new values
    task automatic step(string req, bit r, bit we, int idx, int data, bit inc, int ra, int rb);
        rst = r; wr_en = we; wr_idx = 4'(idx); wr_data = 16'(data);
        ip_inc = inc; rd_a_idx = 4'(ra); rd_b_idx = 4'(rb);
        #1;
        if (!r) check_all("R5");
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < 16; k++) model[k] = 16'h0000;
        end else begin
            if (we && idx != 1 && idx != 2) model[idx] = 16'(data);
            if (inc && !(we && idx == 15)) model[15] = model[15] + 16'd1;
        end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) model[k] = 16'h0000;
        @(negedge clk);
        // R8: reset state across all indices
        step("R8", 1, 0, 0, 0, 0, 0, 1);
        step("R8", 1, 0, 0, 0, 0, 2, 15);
        for (int k = 0; k < 16; k += 2) step("R8", 0, 0, 0, 0, 0, k, k + 1);
        // R1 R4: fill every index, read back on both ports
        for (int k = 0; k < 16; k++) step("R4", 0, 1, k, 16'h1100 + k * 16'h0101, 0, k, (k + 5) % 16);
        for (int k = 0; k < 16; k++) step("R1", 0, 0, 0, 0, 0, k, 15 - k);
        // R2 R3: writes to the constant entries are ignored
        step("R2", 0, 1, 1, 16'hABCD, 0, 1, 1);
        step("R2", 0, 0, 0, 0, 0, 1, 2);
        step("R3", 0, 1, 2, 16'h1234, 0, 2, 1);
        step("R3", 0, 0, 0, 0, 0, 2, 2);
        // R5: read-during-write returns the old value (checked before edge in step)
        step("R5", 0, 1, 7, 16'h5A5A, 0, 7, 7);
        step("R5", 0, 1, 7, 16'hA5A5, 0, 7, 3);
        // R10: both ports on one entry
        step("R10", 0, 0, 0, 0, 0, 7, 7);
        step("R10", 0, 0, 0, 0, 0, 14, 14);
        // R6: increments, hold and wraparound
        step("R6", 0, 1, 15, 16'h0100, 0, 15, 0);
        for (int k = 0; k < 4; k++) step("R6", 0, 0, 0, 0, 1, 15, 14);
        step("R6", 0, 0, 0, 0, 0, 15, 15);
        step("R6", 0, 1, 15, 16'hFFFF, 0, 15, 0);
        step("R6", 0, 0, 0, 0, 1, 15, 0);
        // R7: write beats increment
        step("R7", 0, 1, 15, 16'h4000, 1, 15, 14);
        step("R7", 0, 0, 0, 0, 1, 15, 14);
        // R4: increment of IP with an unrelated write in the same cycle
        step("R4", 0, 1, 14, 16'h0FF0, 1, 14, 15);
        // R8: reset wins over write and increment
        step("R8", 1, 1, 15, 16'h7777, 1, 15, 3);
        for (int k = 0; k < 16; k += 2) step("R8", 0, 0, 0, 0, 0, k, k + 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule